// File: doc/BRIEF.md
# Front Panel Secure-Mode Lockout Controller

This block sits between the front-panel push buttons and the power sequencing logic. It gates five button requests: power, reset, sleep, NMI and chassis identify. Secure mode is on only when the configuration enables it and either the external keyboard-controller secure input or a configured force-on bit is high. While secure mode is on, a rising press on a button whose protect bit is set is dropped. Each dropped press gives a one-cycle violation strobe with a reason code.

A power press counts as a power-down request while the system is on and as a power-up request while it is off. A power-up request is always blocked while secure mode is on. It is also blocked, without a violation, while the separate panel lockout input is high. The NMI and identify buttons always pass.

The block also synchronizes a chassis intrusion input and presents it as a status bit. When intrusion events are enabled, every change of that input gives a one-cycle event. The configuration register is loaded through a write-enable and data port. It is cleared by controller reset, by the power-application input and by the system-reset input.

Top module: `fp_lock_top`

## Requirements
- R1: While secure mode is on and the system is on, a power press is dropped when the protect-power bit (data bit 2) is set. Otherwise a pwr_req_o pulse follows one cycle after the press.
- R2: While secure mode is on, a reset press is dropped when the protect-reset bit (data bit 3) is set. Otherwise rst_req_o pulses one cycle after the press.
- R3: While secure mode is on, a sleep press is dropped when the protect-sleep bit (data bit 4) is set. Otherwise slp_req_o pulses one cycle after the press.
- R4: While the system is off (sys_on_i low), a power press is dropped if secure mode is on, whatever the protect-power bit, or if panel_lock_i is high.
- R5: NMI and identify presses always give a pulse on nmi_req_o or id_req_o one cycle later, whatever the secure state.
- R6: Every press that secure mode drops gives a one-cycle viol_o strobe one cycle after the press. A press blocked only by panel_lock_i gives no strobe.
- R7: While viol_o is high, viol_code_o gives the dropped button: 00 power, 01 reset, 10 sleep. When several presses are dropped in the same cycle, power wins over reset, and reset wins over sleep.
- R8: secure_o equals enable (data bit 0) AND (kbc_secure_i OR force-on, data bit 1). It follows kbc_secure_i in the same cycle.
- R9: intr_state_o is intr_i delayed through two register stages.
- R10: intr_evt_o is high for one cycle after each rise or fall of intr_state_o, but only while the intrusion-event bit (data bit 5) is set.
- R11: The configuration register returns to all zeros one cycle after rst, pwr_apply_i or sys_rst_i is high. A clear takes precedence over a write in the same cycle.
- R12: A button counts as pressed only on a low-to-high change. A button held for many cycles gives exactly one pulse, on its action output or on viol_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high controller reset |
| pwr_apply_i | input | 1 | Power application, clears configuration |
| sys_rst_i | input | 1 | System reset, clears configuration |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_data_i | input | 6 | Configuration data: 0 enable, 1 force-on, 2 protect power, 3 protect reset, 4 protect sleep, 5 intrusion event enable |
| kbc_secure_i | input | 1 | External keyboard-controller secure signal |
| panel_lock_i | input | 1 | Front-panel lockout, blocks power-up |
| sys_on_i | input | 1 | System power state, 1 = on |
| btn_pwr_i | input | 1 | Power button, debounced |
| btn_rst_i | input | 1 | Reset button, debounced |
| btn_slp_i | input | 1 | Sleep button, debounced |
| btn_nmi_i | input | 1 | NMI button, debounced |
| btn_id_i | input | 1 | Chassis identify button, debounced |
| intr_i | input | 1 | Asynchronous chassis intrusion input |
| pwr_req_o | output | 1 | Power request pulse |
| rst_req_o | output | 1 | Reset request pulse |
| slp_req_o | output | 1 | Sleep request pulse |
| nmi_req_o | output | 1 | NMI request pulse |
| id_req_o | output | 1 | Identify request pulse |
| viol_o | output | 1 | Secure-mode violation strobe |
| viol_code_o | output | 2 | Violation reason code |
| secure_o | output | 1 | Effective secure-mode state |
| intr_state_o | output | 1 | Synchronized intrusion state |
| intr_evt_o | output | 1 | Intrusion change event |

## Verification
Action pulses, viol_o and viol_code_o come one clock after the edge that samples the press. A configuration write or clear acts on the edge that samples it, so secure_o changes at once when kbc_secure_i changes and one edge after a configuration update. intr_state_o changes two edges after intr_i, and intr_evt_o is high for exactly that one cycle. The bench drives inputs on the falling edge and compares every output with a reference model just before the next rising edge. Every one of these latencies is therefore checked in every cycle, not only where a directed check looks.

// File: rtl/fp_lock_pkg.sv
package fp_lock_pkg;

    localparam int CFG_W = 6;
    localparam int NBTN  = 5;

    // button slot positions inside the press vector
    localparam int BI_PWR = 0;
    localparam int BI_RST = 1;
    localparam int BI_SLP = 2;
    localparam int BI_NMI = 3;
    localparam int BI_ID  = 4;

    // packed so that bit 0 of the write data lands in 'enable'
    typedef struct packed {
        logic ien;
        logic prot_slp;
        logic prot_rst;
        logic prot_pwr;
        logic force_on;
        logic enable;
    } cfg_t;

    typedef enum logic [1:0] {
        VC_PWR = 2'b00,
        VC_RST = 2'b01,
        VC_SLP = 2'b10
    } viol_code_t;

    function automatic logic secure_eff(cfg_t c, logic kbc);
        return c.enable & (kbc | c.force_on);
    endfunction

    // fixed priority: power, then reset, then sleep
    function automatic viol_code_t pick_code(logic [2:0] hit);
        if (hit[BI_PWR])      return VC_PWR;
        else if (hit[BI_RST]) return VC_RST;
        else                  return VC_SLP;
    endfunction

endpackage

// File: rtl/fp_lock_cfg.sv
module fp_lock_cfg
    import fp_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             we_i,
    input  logic [CFG_W-1:0] data_i,
    output cfg_t             cfg_o
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cfg_q <= '0;
        end else if (we_i) begin
            cfg_q <= cfg_t'(data_i);
        end
    end

    assign cfg_o = cfg_q;

    AST_CFG_CLEARED: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cfg_q == '0)); // R11

endmodule

// File: rtl/fp_lock_edge.sv
module fp_lock_edge #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sig_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/fp_lock_intr.sv
module fp_lock_intr #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic state_o,
    output logic change_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[0] <= 1'b0;
                    else     sync_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[g] <= 1'b0;
                    else     sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[LAST];
    end

    assign state_o  = sync_q[LAST];
    assign change_o = sync_q[LAST] ^ last_q;

endmodule

// File: rtl/fp_lock_top.sv
module fp_lock_top
    import fp_lock_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_apply_i,
    input  logic             sys_rst_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_data_i,
    input  logic             kbc_secure_i,
    input  logic             panel_lock_i,
    input  logic             sys_on_i,
    input  logic             btn_pwr_i,
    input  logic             btn_rst_i,
    input  logic             btn_slp_i,
    input  logic             btn_nmi_i,
    input  logic             btn_id_i,
    input  logic             intr_i,
    output logic             pwr_req_o,
    output logic             rst_req_o,
    output logic             slp_req_o,
    output logic             nmi_req_o,
    output logic             id_req_o,
    output logic             viol_o,
    output logic [1:0]       viol_code_o,
    output logic             secure_o,
    output logic             intr_state_o,
    output logic             intr_evt_o
);
    cfg_t            cfg;
    logic            secure;
    logic [NBTN-1:0] btn_vec;
    logic [NBTN-1:0] rise;
    logic [NBTN-1:0] blk_sec;
    logic [NBTN-1:0] blk_other;
    logic [NBTN-1:0] pass;
    logic [NBTN-1:0] hit;
    logic [NBTN-1:0] act_q;
    logic            viol_q;
    viol_code_t      code_q;
    logic            intr_chg;

    fp_lock_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (pwr_apply_i | sys_rst_i),
        .we_i   (cfg_we_i),
        .data_i (cfg_data_i),
        .cfg_o  (cfg)
    );

    assign btn_vec = {btn_id_i, btn_nmi_i, btn_slp_i, btn_rst_i, btn_pwr_i};

    fp_lock_edge #(.W(NBTN)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (btn_vec),
        .rise_o (rise)
    );

    fp_lock_intr #(.STAGES(SYNC_STAGES)) u_intr (
        .clk      (clk),
        .rst      (rst),
        .async_i  (intr_i),
        .state_o  (intr_state_o),
        .change_o (intr_chg)
    );

    assign secure = secure_eff(cfg, kbc_secure_i);

    always_comb begin
        blk_sec           = '0;
        blk_other         = '0;
        // power-up is always refused under secure mode; power-down only if protected
        blk_sec[BI_PWR]   = secure & (cfg.prot_pwr | ~sys_on_i);
        blk_sec[BI_RST]   = secure & cfg.prot_rst;
        blk_sec[BI_SLP]   = secure & cfg.prot_slp;
        blk_other[BI_PWR] = ~sys_on_i & panel_lock_i;
        hit               = rise & blk_sec;
        pass              = rise & ~blk_sec & ~blk_other;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            viol_q <= 1'b0;
            code_q <= VC_PWR;
        end else begin
            act_q  <= pass;
            viol_q <= |hit;
            if (|hit) code_q <= pick_code(hit[2:0]);
        end
    end

    assign pwr_req_o   = act_q[BI_PWR];
    assign rst_req_o   = act_q[BI_RST];
    assign slp_req_o   = act_q[BI_SLP];
    assign nmi_req_o   = act_q[BI_NMI];
    assign id_req_o    = act_q[BI_ID];
    assign viol_o      = viol_q;
    assign viol_code_o = code_q;
    assign secure_o    = secure;
    assign intr_evt_o  = intr_chg & cfg.ien;

    AST_PWR_DOWN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (rise[BI_PWR] && secure && cfg.prot_pwr && sys_on_i) |=> (!pwr_req_o && viol_o)); // R1

    AST_RST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (rise[BI_RST] && secure && cfg.prot_rst) |=> (!rst_req_o && viol_o)); // R2

    AST_PWR_UP_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (rise[BI_PWR] && !sys_on_i && (panel_lock_i || secure)) |=> !pwr_req_o); // R4

    AST_NMI_EXEMPT: assert property (@(posedge clk) disable iff (rst)
        rise[BI_NMI] |=> nmi_req_o); // R5

    AST_ID_EXEMPT: assert property (@(posedge clk) disable iff (rst)
        rise[BI_ID] |=> id_req_o); // R5

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        viol_o |-> (viol_code_o != 2'b11)); // R7

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        pwr_req_o |=> !pwr_req_o); // R12

    AST_EVT_GATED: assert property (@(posedge clk) disable iff (rst)
        intr_evt_o |-> cfg.ien); // R10

endmodule

// File: tb/fp_lock_top_bench.sv
`timescale 1ns/1ps
module fp_lock_top_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_apply_i = 0, sys_rst_i = 0, cfg_we_i = 0;
    logic [5:0] cfg_data_i = 0;
    logic kbc_secure_i = 0, panel_lock_i = 0, sys_on_i = 1;
    logic btn_pwr_i = 0, btn_rst_i = 0, btn_slp_i = 0, btn_nmi_i = 0, btn_id_i = 0;
    logic intr_i = 0;
    logic pwr_req_o, rst_req_o, slp_req_o, nmi_req_o, id_req_o, viol_o;
    logic [1:0] viol_code_o;
    logic secure_o, intr_state_o, intr_evt_o;

    int checks = 0, bad = 0, cycles = 0, pwr_pulses = 0, viol_pulses = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    fp_lock_top u_fp_lock_top (.*);

    // reference model state
    logic [5:0] m_cfg = 0;
    logic [4:0] m_prev = 0, m_act = 0;
    logic m_viol = 0;
    logic [1:0] m_code = 0;
    logic m_s1 = 0, m_s2 = 0, m_s3 = 0;

    always @(posedge clk) begin
        logic sec;
        logic [4:0] btn, pr, blk, ok;
        btn = {btn_id_i, btn_nmi_i, btn_slp_i, btn_rst_i, btn_pwr_i};
        if (rst) begin
            m_cfg <= 0; m_prev <= 0; m_act <= 0; m_viol <= 0; m_code <= 0;
            m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
        end else begin
            sec = m_cfg[0] && (kbc_secure_i || m_cfg[1]);
            pr  = btn & ~m_prev;
            blk = 0;
            if (sec && (m_cfg[2] || !sys_on_i)) blk[0] = 1;
            if (sec && m_cfg[3]) blk[1] = 1;
            if (sec && m_cfg[4]) blk[2] = 1;
            ok = pr & ~blk;
            if (!sys_on_i && panel_lock_i) ok[0] = 0;
            m_act  <= ok;
            m_viol <= |(pr & blk);
            if (pr[0] && blk[0])      m_code <= 2'd0;
            else if (pr[1] && blk[1]) m_code <= 2'd1;
            else if (pr[2] && blk[2]) m_code <= 2'd2;
            if (pwr_apply_i || sys_rst_i) m_cfg <= 0;
            else if (cfg_we_i)            m_cfg <= cfg_data_i;
            m_prev <= btn;
            m_s1 <= intr_i; m_s2 <= m_s1; m_s3 <= m_s2;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // compare every cycle, half a clock after inputs move
    always @(negedge clk) begin
        #2;
        if (!rst && !finished) begin
            chk(pwr_req_o == m_act[0], "R1 R4 pwr_req", pwr_req_o, m_act[0]);
            chk(rst_req_o == m_act[1], "R2 rst_req", rst_req_o, m_act[1]);
            chk(slp_req_o == m_act[2], "R3 slp_req", slp_req_o, m_act[2]);
            chk(nmi_req_o == m_act[3], "R5 nmi_req", nmi_req_o, m_act[3]);
            chk(id_req_o == m_act[4], "R5 id_req", id_req_o, m_act[4]);
            chk(viol_o == m_viol, "R6 viol", viol_o, m_viol);
            if (m_viol) chk(viol_code_o == m_code, "R7 code", viol_code_o, m_code);
            chk(secure_o == (m_cfg[0] && (kbc_secure_i || m_cfg[1])), "R8 secure",
                secure_o, m_cfg[0] && (kbc_secure_i || m_cfg[1]));
            chk(intr_state_o == m_s2, "R9 intr_state", intr_state_o, m_s2);
            chk(intr_evt_o == (m_cfg[5] && (m_s2 ^ m_s3)), "R10 intr_evt",
                intr_evt_o, m_cfg[5] && (m_s2 ^ m_s3));
            if (pwr_req_o) pwr_pulses++;
            if (viol_o) viol_pulses++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] d);
        @(negedge clk); cfg_we_i = 1; cfg_data_i = d;
        @(negedge clk); cfg_we_i = 0;
    endtask

    // mask bits: 0 pwr 1 rst 2 slp 3 nmi 4 id
    task automatic press(input logic [4:0] m);
        @(negedge clk);
        {btn_id_i, btn_nmi_i, btn_slp_i, btn_rst_i, btn_pwr_i} = m;
        @(negedge clk);
        {btn_id_i, btn_nmi_i, btn_slp_i, btn_rst_i, btn_pwr_i} = 0;
        idle(2);
    endtask

    initial begin
        int p0;
        idle(3);
        @(negedge clk); rst = 0;
        #2;
        chk(pwr_req_o == 0 && viol_o == 0 && secure_o == 0, "R11 reset state", viol_o, 0);
        // secure signal high but not enabled: all pass
        kbc_secure_i = 1;
        press(5'b00111);
        // enable + protect power and reset
        wr(6'b001101);
        press(5'b00001); press(5'b00010); press(5'b00100);
        press(5'b01000); press(5'b10000);
        wr(6'b011101);
        press(5'b00100);
        press(5'b00111);   // priority: power code
        press(5'b00110);   // reset code
        press(5'b11111);
        // secure signal low: passes, then force-on
        kbc_secure_i = 0;
        press(5'b00111);
        wr(6'b011111);
        press(5'b00111);
        // held button: one violation only
        p0 = viol_pulses;
        @(negedge clk); btn_pwr_i = 1; idle(6); btn_pwr_i = 0; idle(2);
        chk(viol_pulses - p0 == 1, "R12 held blocked", viol_pulses - p0, 1);
        // power-up cases
        sys_on_i = 0;
        press(5'b00001);   // secure, off: blocked with violation
        wr(6'b000000);
        panel_lock_i = 1;
        press(5'b00001);   // lockout only: blocked silently
        panel_lock_i = 0;
        p0 = pwr_pulses;
        @(negedge clk); btn_pwr_i = 1; idle(5); btn_pwr_i = 0; idle(2);
        chk(pwr_pulses - p0 == 1, "R12 held pass", pwr_pulses - p0, 1);
        wr(6'b000001); kbc_secure_i = 1;
        press(5'b00001);   // secure, prot_pwr clear, off: still blocked
        sys_on_i = 1;
        press(5'b00001);   // on, not protected: passes
        // intrusion without and with events
        @(negedge clk); intr_i = 1; idle(4); intr_i = 0; idle(4);
        wr(6'b100001);
        @(negedge clk); intr_i = 1; idle(4); intr_i = 0; idle(4);
        @(negedge clk); intr_i = 1; idle(1); intr_i = 0; idle(4);
        // clear sources
        wr(6'b111111);
        @(negedge clk); pwr_apply_i = 1; @(negedge clk); pwr_apply_i = 0;
        #2; chk(secure_o == 0, "R11 power apply", secure_o, 0);
        press(5'b00111);
        wr(6'b111111);
        @(negedge clk); sys_rst_i = 1; cfg_we_i = 1; cfg_data_i = 6'b111111;
        @(negedge clk); sys_rst_i = 0; cfg_we_i = 0;
        #2; chk(secure_o == 0, "R11 sys reset over write", secure_o, 0);
        wr(6'b111111);
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        #2; chk(secure_o == 0, "R11 controller reset", secure_o, 0);
        press(5'b00111);
        idle(4);
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            checks++; bad++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule